// File: doc/BRIEF.md
# Shoot-Through Segment Sequence Generator

This block drives one sampling period of a three-level hybrid inverter whose four slow switches per phase hold still for the whole period. All switching is done by the two fast switches of each phase. A period is an eleven-segment pattern, symmetric about its centre segment. It covers the case where the reference vector sits in the first sector, fifth region. Phase A moves only among P, O+ and U. Phase B moves only among N and O-. Phase C moves only among N, O- and L. This keeps the slow-switch pattern of every phase constant. When boost is enabled, upper (U) and lower (L) shoot-through segments are placed inside the small-vector dwell times.

Six segment lengths, in clock ticks, and a boost flag are sampled on a start strobe. The mirror halves of the pattern share the same lengths. The strobe is a plain control pin with no back-pressure. It is acted on only when no period is running, or on the final tick of a running period. At any other time it is dropped. There is no valid/ready pairing at this block's edge: the upstream dwell-time stage must hold the length inputs valid in the cycle it raises start.

Top module: `shoot_seq_gen`

## Requirements
- R1: Segments 0..10 show these per-phase states (A,B,C), mirror-symmetric about segment 5: 0 O+,N,N; 1 U,N,N; 2 P,N,N; 3 P,O-,N; 4 P,O-,L; 5 P,O-,O-. Segments 6..10 repeat 4..0. State codes: N=000, O-=001, O+=010, P=011, L=100, U=101.
- R2: Segment k lasts exactly the number of ticks of its length slot. Segment k uses slot k for k<=5 and slot 10-k otherwise. The slots are: 0 outer, 1 upper shoot, 2 PNN, 3 mid, 4 lower shoot, 5 centre. Lengths and boost are captured at launch, and input changes during a period have no effect.
- R3: A segment whose effective length is zero is skipped without costing a cycle. A launch whose lengths are all zero produces no period.
- R4: With boost captured low, segments 1, 4, 6 and 9 have zero length whatever their slot values.
- R5: Gate bits per phase are [0] slow1, [1] slow2, [2] slow3, [3] slow4, [4] fast1, [5] fast2. For P, O+ and U: slow1 and slow3 on, slow2 and slow4 off. For N, O- and L: slow2 and slow4 on. The (fast1,fast2) pairs are P(1,0), O+(0,1), U(1,1), N(0,1), O-(1,0), L(1,1).
- R6: Codes 110 and 111 drive all six gates off. While idle, every phase reports 110 and the segment index is 0.
- R7: In every cycle at most one phase is in U or L.
- R8: Within a period the slow bits of every phase stay constant, and each fast bit changes at most twice.
- R9: A start during a period that is not on its final tick is ignored. A start on the final tick launches the next period, whose first segment follows with no idle cycle.
- R10: Synchronous reset forces idle: all gates low and segment index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Launch strobe for one sampling period |
| boost_i | input | 1 | Enables the shoot-through segments |
| len_outer_i | input | LEN_W | Length of segments 0 and 10 |
| len_ust_i | input | LEN_W | Length of segments 1 and 9 |
| len_pnn_i | input | LEN_W | Length of segments 2 and 8 |
| len_mid_i | input | LEN_W | Length of segments 3 and 7 |
| len_lst_i | input | LEN_W | Length of segments 4 and 6 |
| len_ctr_i | input | LEN_W | Length of segment 5 |
| state_a_o | output | 3 | Phase A state code |
| state_b_o | output | 3 | Phase B state code |
| state_c_o | output | 3 | Phase C state code |
| gate_a_o | output | 6 | Phase A gate bits |
| gate_b_o | output | 6 | Phase B gate bits |
| gate_c_o | output | 6 | Phase C gate bits |
| seg_o | output | 4 | Current segment index |

## Verification
The end of one period and the launch of the next can fall in the same cycle: a start raised on the final tick must both close the running pattern and capture new lengths. The bench provokes this by chaining periods, directly and at random. It expects the first non-zero segment of the new period on the very next tick, with no idle code in between. In the other case, a start raised on an earlier tick, it expects the running trace to continue unchanged. Launches whose leading segments are zero exercise the other collision: the skip is resolved in the same cycle as the launch.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  localparam int NSEG  = 11;
  localparam int NSLOT = 6;
  localparam int IDX_W = $clog2(NSEG);
  localparam int GATES = 6;

  typedef enum logic [2:0] {
    ST_N   = 3'b000,
    ST_OM  = 3'b001,
    ST_OP  = 3'b010,
    ST_P   = 3'b011,
    ST_L   = 3'b100,
    ST_U   = 3'b101,
    ST_OFF = 3'b110
  } pstate_t;

  // mirror halves share one length slot
  function automatic int slot_of(input int k);
    return (k <= NSEG / 2) ? k : (NSEG - 1 - k);
  endfunction

  function automatic bit is_boost_slot(input int s);
    return (s == 1) || (s == 4);
  endfunction
endpackage

// File: rtl/ssg_timer.sv
module ssg_timer
  import ssg_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic                         boost_i,
  input  logic [NSLOT-1:0][LEN_W-1:0]  len_i,
  output logic                         busy_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [NSLOT-1:0][LEN_W-1:0] len_q;
  logic                        boost_q;
  logic                        busy_q;
  logic [IDX_W-1:0]            idx_q;
  logic [LEN_W-1:0]            cnt_q;

  logic                        run_found, new_found, run_last, launch;
  logic [IDX_W-1:0]            run_idx, new_idx;
  logic [LEN_W-1:0]            run_len, new_len;

  function automatic logic [LEN_W-1:0] seg_len(
    input logic [NSLOT-1:0][LEN_W-1:0] l, input logic b, input int k);
    int s;
    s = slot_of(k);
    if (!b && is_boost_slot(s)) return '0;
    return l[s];
  endfunction

  // next non-empty segment after the current one, and first one of a new launch
  always_comb begin
    run_found = 1'b0;
    run_idx   = '0;
    run_len   = '0;
    new_found = 1'b0;
    new_idx   = '0;
    new_len   = '0;
    for (int k = NSEG - 1; k >= 0; k--) begin
      if (k > int'(idx_q) && seg_len(len_q, boost_q, k) != '0) begin
        run_found = 1'b1;
        run_idx   = IDX_W'(k);
        run_len   = seg_len(len_q, boost_q, k);
      end
      if (seg_len(len_i, boost_i, k) != '0) begin
        new_found = 1'b1;
        new_idx   = IDX_W'(k);
        new_len   = seg_len(len_i, boost_i, k);
      end
    end
  end

  assign run_last = busy_q && (cnt_q == '0) && !run_found;
  assign launch   = start_i && (!busy_q || run_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= '0;
      boost_q <= 1'b0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (launch) begin
      len_q   <= len_i;
      boost_q <= boost_i;
      busy_q  <= new_found;
      idx_q   <= new_found ? new_idx : '0;
      cnt_q   <= new_found ? new_len - LEN_W'(1) : '0;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - LEN_W'(1);
      end else if (run_found) begin
        idx_q <= run_idx;
        cnt_q <= run_len - LEN_W'(1);
      end else begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/ssg_pattern.sv
module ssg_pattern
  import ssg_pkg::*;
(
  input  logic             busy_i,
  input  logic [IDX_W-1:0] idx_i,
  output pstate_t          st_a_o,
  output pstate_t          st_b_o,
  output pstate_t          st_c_o
);
  always_comb begin
    st_a_o = ST_OFF;
    st_b_o = ST_OFF;
    st_c_o = ST_OFF;
    if (busy_i) begin
      unique case (idx_i)
        4'd0, 4'd10: begin st_a_o = ST_OP; st_b_o = ST_N;  st_c_o = ST_N;  end
        4'd1, 4'd9:  begin st_a_o = ST_U;  st_b_o = ST_N;  st_c_o = ST_N;  end
        4'd2, 4'd8:  begin st_a_o = ST_P;  st_b_o = ST_N;  st_c_o = ST_N;  end
        4'd3, 4'd7:  begin st_a_o = ST_P;  st_b_o = ST_OM; st_c_o = ST_N;  end
        4'd4, 4'd6:  begin st_a_o = ST_P;  st_b_o = ST_OM; st_c_o = ST_L;  end
        4'd5:        begin st_a_o = ST_P;  st_b_o = ST_OM; st_c_o = ST_OM; end
        default:     begin st_a_o = ST_OFF; st_b_o = ST_OFF; st_c_o = ST_OFF; end
      endcase
    end
  end
endmodule

// File: rtl/ssg_gate_dec.sv
module ssg_gate_dec
  import ssg_pkg::*;
(
  input  pstate_t          st_i,
  output logic [GATES-1:0] gate_o
);
  localparam logic [3:0] SLOW_HI = 4'b0101; // slow1, slow3
  localparam logic [3:0] SLOW_LO = 4'b1010; // slow2, slow4

  always_comb begin
    unique case (st_i)
      ST_P:    gate_o = {2'b01, SLOW_HI};
      ST_OP:   gate_o = {2'b10, SLOW_HI};
      ST_U:    gate_o = {2'b11, SLOW_HI};
      ST_N:    gate_o = {2'b10, SLOW_LO};
      ST_OM:   gate_o = {2'b01, SLOW_LO};
      ST_L:    gate_o = {2'b11, SLOW_LO};
      default: gate_o = '0;
    endcase
  end
endmodule

// File: rtl/shoot_seq_gen.sv
module shoot_seq_gen
  import ssg_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             boost_i,
  input  logic [LEN_W-1:0] len_outer_i,
  input  logic [LEN_W-1:0] len_ust_i,
  input  logic [LEN_W-1:0] len_pnn_i,
  input  logic [LEN_W-1:0] len_mid_i,
  input  logic [LEN_W-1:0] len_lst_i,
  input  logic [LEN_W-1:0] len_ctr_i,
  output logic [2:0]       state_a_o,
  output logic [2:0]       state_b_o,
  output logic [2:0]       state_c_o,
  output logic [5:0]       gate_a_o,
  output logic [5:0]       gate_b_o,
  output logic [5:0]       gate_c_o,
  output logic [3:0]       seg_o
);
  localparam int NPH = 3;

  logic [NSLOT-1:0][LEN_W-1:0] len_vec;
  logic                        busy;
  logic [IDX_W-1:0]            idx;
  pstate_t                     st [NPH];
  logic [GATES-1:0]            gt [NPH];

  assign len_vec = {len_ctr_i, len_lst_i, len_mid_i, len_pnn_i, len_ust_i, len_outer_i};

  ssg_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst(rst), .start_i(start_i), .boost_i(boost_i),
    .len_i(len_vec), .busy_o(busy), .idx_o(idx)
  );

  ssg_pattern u_pattern (
    .busy_i(busy), .idx_i(idx),
    .st_a_o(st[0]), .st_b_o(st[1]), .st_c_o(st[2])
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    ssg_gate_dec u_dec (.st_i(st[p]), .gate_o(gt[p]));
  end

  assign state_a_o = st[0];
  assign state_b_o = st[1];
  assign state_c_o = st[2];
  assign gate_a_o  = gt[0];
  assign gate_b_o  = gt[1];
  assign gate_c_o  = gt[2];
  assign seg_o     = 4'(idx);
endmodule

// File: rtl/ssg_chk.sv
module ssg_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state_a_o,
  input logic [2:0] state_b_o,
  input logic [2:0] state_c_o,
  input logic [5:0] gate_a_o,
  input logic [5:0] gate_b_o,
  input logic [5:0] gate_c_o,
  input logic [3:0] seg_o
);
  logic act;
  logic [2:0] shoot;
  assign act = (state_a_o[2:1] != 2'b11);
  assign shoot = {(state_a_o == 3'b101) || (state_a_o == 3'b100),
                  (state_b_o == 3'b101) || (state_b_o == 3'b100),
                  (state_c_o == 3'b101) || (state_c_o == 3'b100)};

  AST_SEG_RANGE: assert property (@(posedge clk) disable iff (rst) seg_o <= 4'd10); // R1
  AST_PHASE_A_SET: assert property (@(posedge clk) disable iff (rst) act |-> (state_a_o == 3'b011 || state_a_o == 3'b010 || state_a_o == 3'b101)); // R1
  AST_FAST_PAIR: assert property (@(posedge clk) disable iff (rst) (act && !shoot[2]) |-> (gate_a_o[4] != gate_a_o[5])); // R5
  AST_SHOOT_BOTH: assert property (@(posedge clk) disable iff (rst) shoot[0] |-> (gate_c_o[5:4] == 2'b11)); // R5
  AST_OFF_GATES: assert property (@(posedge clk) disable iff (rst) (state_b_o[2:1] == 2'b11) |-> (gate_b_o == 6'd0)); // R6
  AST_ONE_SHOOT: assert property (@(posedge clk) disable iff (rst) $onehot0(shoot)); // R7
  AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (rst) (act && $past(act) && seg_o > $past(seg_o)) |-> (gate_a_o[3:0] == $past(gate_a_o[3:0]) && gate_b_o[3:0] == $past(gate_b_o[3:0]) && gate_c_o[3:0] == $past(gate_c_o[3:0]))); // R8
  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (seg_o == 4'd0 && gate_a_o == 6'd0 && gate_b_o == 6'd0 && gate_c_o == 6'd0)); // R10
endmodule

bind shoot_seq_gen ssg_chk u_chk (
  .clk(clk), .rst(rst),
  .state_a_o(state_a_o), .state_b_o(state_b_o), .state_c_o(state_c_o),
  .gate_a_o(gate_a_o), .gate_b_o(gate_b_o), .gate_c_o(gate_c_o),
  .seg_o(seg_o)
);

// File: tb/tb_shoot_seq_gen.sv
module tb_shoot_seq_gen;
  typedef logic [5:0][7:0] lens_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic boost = 1'b0;
  lens_t lin = '0;
  logic [2:0] st_a, st_b, st_c;
  logic [5:0] g_a, g_b, g_c;
  logic [3:0] seg;
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  shoot_seq_gen dut (
    .clk(clk), .rst(rst), .start_i(start), .boost_i(boost),
    .len_outer_i(lin[0]), .len_ust_i(lin[1]), .len_pnn_i(lin[2]),
    .len_mid_i(lin[3]), .len_lst_i(lin[4]), .len_ctr_i(lin[5]),
    .state_a_o(st_a), .state_b_o(st_b), .state_c_o(st_c),
    .gate_a_o(g_a), .gate_b_o(g_b), .gate_c_o(g_c), .seg_o(seg)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int blen(input lens_t l, input bit b, input int k);
    int s;
    s = (k <= 5) ? k : 10 - k;
    if (!b && (s == 1 || s == 4)) return 0;
    return int'(l[s]);
  endfunction

  function automatic logic [2:0] exp_state(input int k, input int ph);
    if (ph == 0) return (k == 0 || k == 10) ? 3'b010 : (k == 1 || k == 9) ? 3'b101 : 3'b011;
    if (ph == 1) return (k >= 3 && k <= 7) ? 3'b001 : 3'b000;
    return (k == 4 || k == 6) ? 3'b100 : (k == 5) ? 3'b001 : 3'b000;
  endfunction

  function automatic logic [5:0] exp_gate(input logic [2:0] s);
    case (s)
      3'b011:  return 6'b01_0101;
      3'b010:  return 6'b10_0101;
      3'b101:  return 6'b11_0101;
      3'b000:  return 6'b10_1010;
      3'b001:  return 6'b01_1010;
      3'b100:  return 6'b11_1010;
      default: return 6'b00_0000;
    endcase
  endfunction

  function automatic lens_t rnd_lens();
    lens_t l;
    for (int i = 0; i < 6; i++) l[i] = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 4));
    return l;
  endfunction

  task automatic chk_idle(input string tag);
    chk(st_a == 3'b110 && st_b == 3'b110 && st_c == 3'b110, {tag, " idle code"}, int'(st_a), 6);
    chk(g_a == 0 && g_b == 0 && g_c == 0, {tag, " gates off"}, int'({g_a, g_b, g_c}), 0);
    chk(seg == 0, {tag, " idle index"}, int'(seg), 0);
  endtask

  // one period; pre: already launched by the previous call; chain: start next on final tick
  task automatic run(input lens_t l, input bit b, input bit pre, input bit chain,
                     input lens_t nl, input bit nb, input bit junk);
    int tot, t, tg_a, tg_b, tg_c, nsh;
    logic [5:0] pa, pb, pc, fa, fb, fc;
    tot = 0; t = 0; tg_a = 0; tg_b = 0; tg_c = 0;
    for (int k = 0; k < 11; k++) tot += blen(l, b, k);
    if (!pre) begin
      lin = l; boost = b; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    lin = rnd_lens(); boost = ~b;   // scrambled inputs must not matter (R2)
    if (tot == 0) begin
      chk_idle("R3 empty launch");
      return;
    end
    fa = g_a; fb = g_b; fc = g_c; pa = g_a; pb = g_b; pc = g_c;
    for (int k = 0; k < 11; k++) begin
      for (int j = 0; j < blen(l, b, k); j++) begin
        chk(seg == 4'(k), "R2 R3 R4 R9 segment index", int'(seg), k);
        chk(st_a == exp_state(k, 0) && st_b == exp_state(k, 1) && st_c == exp_state(k, 2),
            "R1 phase states", int'({st_a, st_b, st_c}),
            int'({exp_state(k, 0), exp_state(k, 1), exp_state(k, 2)}));
        chk(g_a == exp_gate(st_a) && g_b == exp_gate(st_b) && g_c == exp_gate(st_c),
            "R5 gate decode", int'({g_a, g_b, g_c}),
            int'({exp_gate(st_a), exp_gate(st_b), exp_gate(st_c)}));
        nsh = int'(st_a[2]) + int'(st_b[2]) + int'(st_c[2]);
        chk(nsh <= 1, "R7 single shoot-through phase", nsh, 1);
        chk(g_a[3:0] == fa[3:0] && g_b[3:0] == fb[3:0] && g_c[3:0] == fc[3:0],
            "R8 slow gates constant", int'({g_a[3:0], g_b[3:0], g_c[3:0]}),
            int'({fa[3:0], fb[3:0], fc[3:0]}));
        tg_a += int'(g_a[4] != pa[4]) + int'(g_a[5] != pa[5]) * 16;
        tg_b += int'(g_b[4] != pb[4]) + int'(g_b[5] != pb[5]) * 16;
        tg_c += int'(g_c[4] != pc[4]) + int'(g_c[5] != pc[5]) * 16;
        pa = g_a; pb = g_b; pc = g_c;
        if (t == tot - 1 && chain) begin
          lin = nl; boost = nb; start = 1'b1;
        end else if (junk && t < tot - 1 && $urandom_range(0, 3) == 0) begin
          lin = rnd_lens(); start = 1'b1;        // R9 mid-period start ignored
        end
        t++;
        @(posedge clk); #1;
        start = 1'b0;
      end
    end
    chk((tg_a % 16) <= 2 && (tg_a / 16) <= 2 && (tg_b % 16) <= 2 && (tg_b / 16) <= 2 &&
        (tg_c % 16) <= 2 && (tg_c / 16) <= 2, "R8 fast toggles per period",
        tg_a + tg_b + tg_c, 0);
    if (!chain) chk_idle("R6 R9 after period");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    lens_t a, n;
    bit ch, nb;
    void'($urandom(32'd31337));
    repeat (3) @(posedge clk);
    #1;
    chk_idle("R10 reset");
    rst = 1'b0;
    @(posedge clk); #1;
    chk_idle("R6 idle before start");

    // full pattern with boost
    a = {8'd3, 8'd2, 8'd2, 8'd1, 8'd2, 8'd2};
    run(a, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    // boost off drops U and L segments (R4)
    run(a, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
    // zero-length leading and centre segments skipped (R3)
    a = {8'd0, 8'd1, 8'd2, 8'd3, 8'd0, 8'd0};
    run(a, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    // all lengths zero
    run('0, 1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    // single-tick segments, back-to-back chain (R9)
    a = {8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 8'd1};
    n = {8'd2, 8'd0, 8'd1, 8'd1, 8'd3, 8'd0};
    run(a, 1'b1, 1'b0, 1'b1, n, 1'b0, 1'b1);
    run(n, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);

    // reset in the middle of a period (R10)
    lin = {8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4}; boost = 1'b1; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    rst = 1'b1;
    @(posedge clk); #1;
    chk_idle("R10 reset mid-period");
    rst = 1'b0;
    @(posedge clk); #1;
    chk_idle("R10 stays idle after reset");

    // constrained random periods, with random chaining
    a = rnd_lens(); nb = 1'b0; ch = 1'b0;
    for (int i = 0; i < 150; i++) begin
      bit b, pre;
      int sum;
      b = (i == 0) ? 1'($urandom_range(0, 1)) : nb;
      pre = ch;
      n = rnd_lens();
      nb = 1'($urandom_range(0, 1));
      sum = 0;
      for (int k = 0; k < 11; k++) sum += blen(a, b, k);
      ch = (sum > 0) && ($urandom_range(0, 1) == 1);
      run(a, b, pre, ch, n, nb, 1'b1);
      a = n;
      if (!ch) @(posedge clk);
      if (!ch) #1;
    end
    if (ch) run(a, nb, 1'b1, 1'b0, '0, 1'b0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule